// File: doc/BRIEF.md
# Register-Mapped I2C Byte Master

This block is an I2C bus master that software steers one byte at a time through a 32-bit register window. Software first loads the data register with an address byte or a payload byte. It then writes the control word. That word enables the core and the clock, names the operation (address phase with a start condition, or a plain data byte), and can add a stop condition after the byte and a not-acknowledge on a received byte. A bit in the same word launches the byte and clears itself. The block drives SCL and SDA as open-drain pull-down enables. Each SCL half-period lasts a programmable number of core clocks.

Results land in a status word. It carries the acknowledge outcome, byte-sent and byte-received events, controller-busy and bus-busy flags. A read of the status word clears its event field. A single level interrupt is formed by masking each event bit with an enable bit that sits four positions higher in the control word. Reads are returned one clock after the read strobe.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the registers read as follows: control at 0x00 is 0, status at 0x04 is 0, divider at 0x08 is 0, data at 0x0C is 0, slave address at 0x10 is 0, timing at 0x14 is 0x00000401, bus monitor at 0x18 is 0x3 (bit 1 SDA level, bit 0 SCL level), revision at 0x30 is 0x00011000, and any unmapped offset is 0.
- R2: The data register at 0x0C stores only bits 7:0 of a write. Its upper bits read as zero.
- R3: A byte transfer starts only when one control write sets bit 1 (core enable), bit 2 (clock enable) and bit 7 (launch) together with bit 0 clear. Any other control write leaves both bus lines released and status bit 2 clear.
- R4: Control bit 7 (launch) and bit 0 (soft reset) always read back as zero. A control write with bit 0 set clears the data register and the stored status bits.
- R5: A launch with bit 4 (start) set produces a start condition and shifts out the data register, MSB first, as the address byte. Bit 0 of that byte is the direction, 1 meaning read, and is kept for the following bytes. An acknowledged address sets status bit 4 (byte sent) and bit 1 (ACK). An unacknowledged address leaves both bits clear.
- R6: A launch without start, in write direction, shifts out the data register byte and then sets status bits 4 and 1.
- R7: A launch without start, in read direction, shifts in a byte, stores it in the data register and sets status bit 5 (byte received) and bit 1. The master pulls SDA low in the acknowledge slot unless control bit 6 (NACK) is set, in which case SDA stays released.
- R8: Control bit 5 (stop) appends a stop condition after the byte. Status bit 3 (bus busy) is set from the start condition until the stop condition.
- R9: A status read returns the stored bits ORed with bus busy (bit 3) and controller busy (bit 2). It then clears bits 11:4.
- R10: The interrupt output is high while any status bit n in 11:4 is set together with control bit n+4. A status read drops it.
- R11: Status bit 2 is set from the accepted launch until the byte, and any stop, is complete. Control writes that arrive while it is set have no effect.
- R12: Each SCL half-period lasts divider + 2 core clocks. SDA changes while SCL is high only for a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Level interrupt |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
Two situations are the hardest to reach from the ports: a control write arriving mid-byte, and the last byte of a read burst, where the master must leave SDA released while the slave watches the acknowledge slot. The bench issues a soft-reset control write a few clocks after launching an address byte. It then confirms that the data and control words kept their values and that the status still reports the completed address phase. A bench slave model answers on the wired-AND bus, sources random read bytes, and records the level it sees in each master acknowledge slot. A burst of acknowledged reads ending in a NACK-plus-stop byte therefore exposes the acknowledge drive directly.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_DIV  = 8'h08;
  localparam logic [7:0] OFF_DATA = 8'h0C;
  localparam logic [7:0] OFF_SADR = 8'h10;
  localparam logic [7:0] OFF_TMG  = 8'h14;
  localparam logic [7:0] OFF_MON  = 8'h18;
  localparam logic [7:0] OFF_REV  = 8'h30;

  localparam logic [31:0] REV_VALUE = 32'h0001_1000;
  localparam logic [31:0] TMG_RESET = 32'h0000_0401;

  localparam int CB_RST   = 0;
  localparam int CB_CORE  = 1;
  localparam int CB_SCL   = 2;
  localparam int CB_START = 4;
  localparam int CB_STOP  = 5;
  localparam int CB_NACK  = 6;
  localparam int CB_LAUNCH = 7;

  localparam int SB_ACK  = 1;
  localparam int SB_SENT = 4;
  localparam int SB_RECV = 5;

  localparam logic [31:0] SELF_CLEAR_MASK = 32'h0000_0081;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_REL,
    ST_START_SCL,
    ST_START_SDA,
    ST_BIT_LOW,
    ST_BIT_HIGH,
    ST_STOP_LOW,
    ST_STOP_SCL,
    ST_STOP_SDA
  } eng_state_e;
endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b1;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= '1;
        else     r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_bm_halfper.sv
module i2c_bm_halfper #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = {1'b0, div} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == last) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= (cnt + 1'b1 == last);
    end
  end
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_nack,
  input  logic             cmd_read,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] div,
  input  logic             sda_in,
  output logic             busy,
  output logic             done,
  output logic             ack_ok,
  output logic [7:0]       rx_byte,
  output logic             bus_busy,
  output logic             scl_pull,
  output logic             sda_pull
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  eng_state_e st;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       stop_q, nack_q, read_q;
  logic       tick;

  i2c_bm_halfper #(.DIV_W(DIV_W)) u_halfper (
    .clk  (clk),
    .rst  (rst),
    .run  (st != ST_IDLE),
    .div  (div),
    .tick (tick)
  );

  function automatic logic pull_for(input logic [3:0] n, input logic [7:0] d,
                                    input logic rd, input logic nk);
    if (n == ACK_SLOT) return rd && !nk;
    return rd ? 1'b0 : !d[3'd7 - n[2:0]];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitn     <= '0;
      sh       <= '0;
      stop_q   <= 1'b0;
      nack_q   <= 1'b0;
      read_q   <= 1'b0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      bus_busy <= 1'b0;
      done     <= 1'b0;
      ack_ok   <= 1'b0;
      rx_byte  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          sh     <= tx_byte;
          stop_q <= cmd_stop;
          nack_q <= cmd_nack;
          read_q <= cmd_read;
          bitn   <= '0;
          if (cmd_start) begin
            st       <= ST_START_REL;
            sda_pull <= 1'b0;
          end else begin
            st       <= ST_BIT_LOW;
            scl_pull <= 1'b1;
            sda_pull <= pull_for(4'd0, tx_byte, cmd_read, cmd_nack);
          end
        end
        ST_START_REL: if (tick) begin
          st       <= ST_START_SCL;
          scl_pull <= 1'b0;
        end
        ST_START_SCL: if (tick) begin
          st       <= ST_START_SDA;
          sda_pull <= 1'b1;
          bus_busy <= 1'b1;
        end
        ST_START_SDA: if (tick) begin
          st       <= ST_BIT_LOW;
          scl_pull <= 1'b1;
          sda_pull <= pull_for(4'd0, sh, read_q, nack_q);
        end
        ST_BIT_LOW: if (tick) begin
          st       <= ST_BIT_HIGH;
          scl_pull <= 1'b0;
        end
        ST_BIT_HIGH: if (tick) begin
          scl_pull <= 1'b1;
          if (bitn == ACK_SLOT) begin
            ack_ok <= !sda_in;
            if (stop_q) begin
              st       <= ST_STOP_LOW;
              sda_pull <= 1'b1;
            end else begin
              st       <= ST_IDLE;
              sda_pull <= 1'b0;
              done     <= 1'b1;
            end
          end else begin
            rx_byte  <= {rx_byte[6:0], sda_in};
            bitn     <= bitn + 4'd1;
            st       <= ST_BIT_LOW;
            sda_pull <= pull_for(bitn + 4'd1, sh, read_q, nack_q);
          end
        end
        ST_STOP_LOW: if (tick) begin
          st       <= ST_STOP_SCL;
          scl_pull <= 1'b0;
        end
        ST_STOP_SCL: if (tick) begin
          st       <= ST_STOP_SDA;
          sda_pull <= 1'b0;
          bus_busy <= 1'b0;
        end
        ST_STOP_SDA: if (tick) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);

  // R8
  bus_busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> (!scl_pull && sda_pull));
  // R8
  bus_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> (!scl_pull && !sda_pull));
  // R12
  scl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && !tick) |=> $stable(scl_pull));
  // R12
  sda_while_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull)))
      |-> (st == ST_START_SDA || st == ST_STOP_SDA));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              sda_in
);
  localparam int EV_LO = 4;
  localparam int EV_HI = 11;
  localparam int EN_SHIFT = 4;

  logic [31:0] ctrl_q, stat_q, div_q, sadr_q, tmg_q;
  logic [31:0] ctrl_n, stat_n;
  logic [7:0]  data_q, data_n;
  logic        dir_q, cmd_start_q, cmd_read_q;
  logic [31:0] rdata_q;
  logic        irq_q;

  logic        eng_busy, eng_done, eng_ack, eng_bb;
  logic [7:0]  eng_rx;
  logic        sda_s;

  logic        wr_ctrl, accept, go, rd_stat;
  logic [31:0] stat_view, rd_mux;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  assign wr_ctrl = reg_wr && at(reg_addr, OFF_CTRL);
  assign accept  = wr_ctrl && !eng_busy;
  assign go      = accept && !reg_wdata[CB_RST] && reg_wdata[CB_CORE]
                   && reg_wdata[CB_SCL] && reg_wdata[CB_LAUNCH];
  assign rd_stat = reg_rd && at(reg_addr, OFF_STAT);
  assign stat_view = stat_q | {28'd0, eng_bb, eng_busy, 2'b00};

  i2c_bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sda_in),
    .q   (sda_s)
  );

  i2c_bm_engine #(.DIV_W(DIV_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .cmd_start (reg_wdata[CB_START]),
    .cmd_stop  (reg_wdata[CB_STOP]),
    .cmd_nack  (reg_wdata[CB_NACK]),
    .cmd_read  (!reg_wdata[CB_START] && dir_q),
    .tx_byte   (data_q),
    .div       (div_q[DIV_W-1:0]),
    .sda_in    (sda_s),
    .busy      (eng_busy),
    .done      (eng_done),
    .ack_ok    (eng_ack),
    .rx_byte   (eng_rx),
    .bus_busy  (eng_bb),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull)
  );

  always_comb begin
    ctrl_n = ctrl_q;
    stat_n = stat_q;
    data_n = data_q;
    if (rd_stat) stat_n[EV_HI:EV_LO] = '0;
    if (accept) begin
      ctrl_n = reg_wdata & ~SELF_CLEAR_MASK;
      if (reg_wdata[CB_RST]) begin
        data_n = '0;
        stat_n = '0;
      end else if (go) begin
        stat_n[SB_ACK] = 1'b0;
      end
    end
    if (reg_wr && at(reg_addr, OFF_DATA)) data_n = reg_wdata[7:0];
    if (eng_done) begin
      if (cmd_start_q) begin
        if (eng_ack) begin
          stat_n[SB_SENT] = 1'b1;
          stat_n[SB_ACK]  = 1'b1;
        end
      end else if (cmd_read_q) begin
        data_n          = eng_rx;
        stat_n[SB_RECV] = 1'b1;
        stat_n[SB_ACK]  = 1'b1;
      end else begin
        stat_n[SB_SENT] = 1'b1;
        stat_n[SB_ACK]  = 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (at(reg_addr, OFF_CTRL)) rd_mux = ctrl_q;
    else if (at(reg_addr, OFF_STAT)) rd_mux = stat_view;
    else if (at(reg_addr, OFF_DIV))  rd_mux = div_q;
    else if (at(reg_addr, OFF_DATA)) rd_mux = {24'd0, data_q};
    else if (at(reg_addr, OFF_SADR)) rd_mux = sadr_q;
    else if (at(reg_addr, OFF_TMG))  rd_mux = tmg_q;
    else if (at(reg_addr, OFF_MON))  rd_mux = {30'd0, sda_s, !scl_pull};
    else if (at(reg_addr, OFF_REV))  rd_mux = REV_VALUE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      stat_q      <= '0;
      div_q       <= '0;
      sadr_q      <= '0;
      tmg_q       <= TMG_RESET;
      data_q      <= '0;
      dir_q       <= 1'b0;
      cmd_start_q <= 1'b0;
      cmd_read_q  <= 1'b0;
      rdata_q     <= '0;
      irq_q       <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      stat_q <= stat_n;
      data_q <= data_n;
      irq_q  <= |(stat_n[EV_HI:EV_LO] & ctrl_n[EV_HI+EN_SHIFT:EV_LO+EN_SHIFT]);
      if (reg_wr && at(reg_addr, OFF_DIV))  div_q  <= reg_wdata;
      if (reg_wr && at(reg_addr, OFF_SADR)) sadr_q <= reg_wdata;
      if (reg_wr && at(reg_addr, OFF_TMG))  tmg_q  <= reg_wdata;
      if (go) begin
        cmd_start_q <= reg_wdata[CB_START];
        cmd_read_q  <= !reg_wdata[CB_START] && dir_q;
        if (reg_wdata[CB_START]) dir_q <= data_q[0];
      end
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

  // R4
  self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!ctrl_q[CB_RST] && !ctrl_q[CB_LAUNCH]));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && eng_busy) |=> $stable(ctrl_q));
  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !eng_done) |=> (stat_q[EV_HI:EV_LO] == '0));
  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q[EV_HI:EV_LO] & ctrl_q[EV_HI+EN_SHIFT:EV_LO+EN_SHIFT])) |-> irq_q);
  // R11
  busy_launch_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> eng_busy);
endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SLV_ADDR = 7'h52;
  localparam logic [31:0] EN = 32'h06, LAUNCH = 32'h80, STA = 32'h10,
                          STO = 32'h20, NAK = 32'h40, DT_IE = 32'h100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, scl_pull, sda_pull;
  logic slv_low = 1'b0;
  wire scl_w = !scl_pull;
  wire sda_w = !(sda_pull | slv_low);

  int checks = 0, errors = 0;
  int div_val = 3;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_master dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_w)
  );

  // bench slave: 0 idle, 1 address, 2 write, 3 read
  int mode = 0, bc = 0, rd_idx = 0, wr_cnt = 0;
  logic [7:0] sh = '0, wr_last = '0;
  logic [7:0] rd_q [8];
  logic m_ack = 1'b0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(scl_w or sda_w) begin
    if (scl_w && p_scl && p_sda && !sda_w) begin
      mode = 1; bc = 0; slv_low = 1'b0;
    end else if (scl_w && p_scl && !p_sda && sda_w) begin
      mode = 0; slv_low = 1'b0;
    end else if (scl_w && !p_scl) begin
      if (bc < 8) sh = {sh[6:0], sda_w};
      if (bc == 8 && mode == 3) begin
        m_ack = sda_w;
        if (sda_w) mode = 0;
      end
      bc = bc + 1;
    end else if (!scl_w && p_scl) begin
      if (bc == 8) begin
        if (mode == 1) begin
          if (sh[7:1] == SLV_ADDR) begin
            slv_low = 1'b1;
            mode = sh[0] ? 3 : 2;
            rd_idx = 0;
          end else mode = 0;
        end else if (mode == 2) begin
          slv_low = 1'b1; wr_last = sh; wr_cnt = wr_cnt + 1;
        end else if (mode == 3) begin
          slv_low = 1'b0; rd_idx = rd_idx + 1;
        end
      end else if (bc == 9) begin
        bc = 0;
        slv_low = (mode == 3) ? !rd_q[rd_idx][7] : 1'b0;
      end else if (bc >= 1 && bc <= 7 && mode == 3) begin
        slv_low = !rd_q[rd_idx][3'(7 - bc)];
      end
    end
    p_scl = scl_w; p_sda = sda_w;
  end

  // SCL high-phase length monitor
  int hi_cnt = 0, last_hi = 0;
  always @(posedge clk) begin
    if (scl_w) hi_cnt <= hi_cnt + 1;
    else if (hi_cnt != 0) begin last_hi <= hi_cnt; hi_cnt <= 0; end
  end

  function automatic logic [31:0] stat_exp(input logic ack, input logic sent,
                                           input logic recv, input logic bb);
    return {26'd0, recv, sent, bb, 1'b0, ack, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic xfer_wait();
    repeat ((div_val + 2) * 26 + 10) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] b;
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h04, v); chk("R1 status", v, 32'h0);
    rd(8'h08, v); chk("R1 divider", v, 32'h0);
    rd(8'h0C, v); chk("R1 data", v, 32'h0);
    rd(8'h14, v); chk("R1 timing", v, 32'h401);
    rd(8'h18, v); chk("R1 monitor", v, 32'h3);
    rd(8'h30, v); chk("R1 revision", v, 32'h0001_1000);
    rd(8'h1C, v); chk("R1 unmapped", v, 32'h0);

    // R2 data width
    wr(8'h0C, 32'hABCD_EF12);
    rd(8'h0C, v); chk("R2 data low byte", v, 32'h12);

    // R3 incomplete enable: no transfer
    wr(8'h00, 32'h84);
    repeat (6) @(negedge clk);
    rd(8'h04, v); chk("R3 no busy", v, 32'h0);
    chk("R3 lines released", {30'd0, scl_w, sda_w}, 32'h3);
    rd(8'h00, v); chk("R4 launch reads zero", v, 32'h04);

    // R5 address write phase, R11 ignored write, R10 irq
    wr(8'h08, div_val);
    wr(8'h0C, {24'd0, SLV_ADDR, 1'b0});
    wr(8'h00, DT_IE | EN | LAUNCH | STA);
    repeat (3) @(negedge clk);
    rd(8'h04, v); chk("R11 busy during byte", v & 32'h4, 32'h4);
    wr(8'h00, 32'h01);
    xfer_wait();
    chk("R10 irq on sent", {31'd0, irq}, 32'h1);
    rd(8'h0C, v); chk("R11 data kept", v, {24'd0, SLV_ADDR, 1'b0});
    rd(8'h00, v); chk("R11 ctrl kept", v, 32'h116);
    rd(8'h04, v); chk("R5 address acked", v, stat_exp(1, 1, 0, 1));
    chk("R10 irq cleared by read", {31'd0, irq}, 32'h0);
    rd(8'h04, v); chk("R9 events cleared", v, stat_exp(1, 0, 0, 1));

    // R6 random write bytes
    for (int i = 0; i < 5; i++) begin
      b = 8'($urandom);
      wr(8'h0C, {24'd0, b});
      wr(8'h00, EN | LAUNCH);
      xfer_wait();
      chk("R6 slave byte", {24'd0, wr_last}, {24'd0, b});
      rd(8'h04, v); chk("R6 status", v, stat_exp(1, 1, 0, 1));
    end
    chk("R12 scl high phase", last_hi, div_val + 2);

    // R8 last byte with stop
    b = 8'($urandom);
    wr(8'h0C, {24'd0, b});
    wr(8'h00, EN | LAUNCH | STO);
    xfer_wait();
    chk("R8 stop byte", {24'd0, wr_last}, {24'd0, b});
    rd(8'h04, v); chk("R8 bus free", v, stat_exp(1, 1, 0, 0));
    chk("R8 lines idle", {30'd0, scl_w, sda_w}, 32'h3);

    // R5 address not acknowledged
    wr(8'h0C, {24'd0, 7'h33, 1'b0});
    wr(8'h00, EN | LAUNCH | STA);
    xfer_wait();
    rd(8'h04, v); chk("R5 address nack", v, stat_exp(0, 0, 0, 1));
    wr(8'h00, EN | LAUNCH | STO);
    xfer_wait();
    rd(8'h04, v); chk("R8 stop after nack", v, stat_exp(1, 1, 0, 0));

    // R7 read burst with a new divider
    div_val = int'($urandom_range(1, 6));
    wr(8'h08, div_val);
    for (int i = 0; i < 8; i++) rd_q[i] = 8'($urandom);
    wr(8'h0C, {24'd0, SLV_ADDR, 1'b1});
    wr(8'h00, EN | LAUNCH | STA);
    xfer_wait();
    rd(8'h04, v); chk("R5 read address", v, stat_exp(1, 1, 0, 1));
    for (int i = 0; i < 3; i++) begin
      wr(8'h00, EN | LAUNCH);
      xfer_wait();
      rd(8'h0C, v); chk("R7 read byte", v, {24'd0, rd_q[i]});
      rd(8'h04, v); chk("R7 status", v, stat_exp(1, 0, 1, 1));
      chk("R7 master ack low", {31'd0, m_ack}, 32'h0);
    end
    chk("R12 scl high phase read", last_hi, div_val + 2);
    wr(8'h00, EN | LAUNCH | NAK | STO);
    xfer_wait();
    rd(8'h0C, v); chk("R7 last byte", v, {24'd0, rd_q[3]});
    rd(8'h04, v); chk("R7 last status", v, stat_exp(1, 0, 1, 0));
    chk("R7 nack released", {31'd0, m_ack}, 32'h1);

    // R4 soft reset clears data and status
    wr(8'h0C, {24'd0, SLV_ADDR, 1'b0});
    wr(8'h00, EN | LAUNCH | STA);
    xfer_wait();
    wr(8'h00, 32'h01);
    rd(8'h04, v); chk("R4 status cleared", v, stat_exp(0, 0, 0, 1));
    rd(8'h0C, v); chk("R4 data cleared", v, 32'h0);
    rd(8'h00, v); chk("R4 reset reads zero", v, 32'h0);
    wr(8'h00, EN | LAUNCH | STO);
    xfer_wait();
    rd(8'h04, v); chk("R8 final stop", v, stat_exp(1, 1, 0, 0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule